// File: doc/BRIEF.md
# Single-Frame Register-Mapped Packet Buffer

This block sits between a 32-bit register bus and a byte-wide MAC interface. It holds one outgoing and one incoming frame with no DMA. On the transmit side, software writes the frame one 32-bit word at a time through a fixed data port. It then writes the byte count and the ownership bit to the transmit control register in a single write. The hardware streams the bytes to the MAC and hands ownership back when the last byte is taken.

On the receive side, the MAC writes a frame into the receive buffer byte by byte. When the frame ends, the hardware posts the length and the error flags. Software then drains the frame through a fixed data port and frees the buffer by writing the receive control register with the ownership bit clear. A frame that starts while software still owns the buffer is discarded whole.

Transmit completion and receive-ready are two interrupt causes. Each has its own enable bit, and the enabled causes are ORed onto one line. Words on the bus are big-endian: the first byte of a frame sits in bits [31:24] of a data word.

Top module: `frame_mailbox`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low and `tx_valid_o` is low.
- R2: The transmit control register is at 0x800, with bit 15 = ready/owned-by-hardware, bit 14 = transmit error and bits [10:0] = byte length. A write with bit 15 set while the ready bit is clear starts a transmission and clears the error bit and the tx_done cause.
- R3: Each write to 0x808 stores the next 32-bit word, whose bits [31:24] hold the earliest byte. Writes made while the ready bit is set, or made after BUF_WORDS words, are dropped. The word pointer returns to zero at each launch.
- R4: The bytes of the frame appear on `tx_data_o` in order, with `tx_valid_o`. The stream advances only on cycles where `tx_ready_i` is high. `tx_last_o` marks byte number length-1.
- R5: When the last byte is accepted, the ready bit clears, the error bit takes the value of `tx_fail_i` in that cycle, and tx_done sets. A launch with length zero completes in the next cycle and emits no bytes.
- R6: A write to 0x800 while the ready bit is set has no effect.
- R7: The receive control register is at 0x810, with bit 15 = frame present, bit 14 = error (any `rx_err_i` during the frame), bit 13 = CRC error (`rx_crc_err_i` with the last byte) and bits [10:0] = byte count. All of these are posted together when the last byte is accepted.
- R8: Each read of 0x818 returns the next stored word, big-endian. Byte lanes past the end of the frame read zero.
- R9: A write to 0x810 with bit 15 clear releases the buffer: the register reads zero and the read pointer returns to the first word.
- R10: A frame whose first byte arrives while the frame-present bit is set is dropped in full, and the posted frame stays unchanged.
- R11: The enable register is at 0x8C0 and the cause register at 0x8C4, with bit 1 = tx_done and bit 0 = rx_rdy (the frame-present level). `irq_o` is the OR of the enabled causes, so an enable of zero masks both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (advances the RX data port) |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, same cycle |
| irq_o | output | 1 | Combined interrupt |
| tx_data_o | output | 8 | Transmit byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | MAC accepts the byte |
| tx_fail_i | input | 1 | MAC reports a send failure, sampled with the last byte |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_last_i | input | 1 | Final received byte |
| rx_err_i | input | 1 | Receive error on this byte |
| rx_crc_err_i | input | 1 | CRC error, sampled with the last byte |

## Verification
The assertions check the per-cycle invariants on every clock. A stalled byte must hold its value. Taking the last byte must end the stream and raise tx_done. A busy transmit side must ignore data-port writes and control writes. A posted receive frame must survive until it is released. A present, enabled frame must drive the interrupt line. Only the bench scenarios can show end-to-end content: byte order across words, the zero padding of the last word, the error and CRC flags, the complete discard of a frame that collides with a held buffer, and the word-pointer cap at the buffer depth.

// File: rtl/frame_mailbox_pkg.sv
package frame_mailbox_pkg;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 11;

  localparam logic [ADDR_W-1:0] OFS_TX_CTL    = 12'h800;
  localparam logic [ADDR_W-1:0] OFS_TX_DAT    = 12'h808;
  localparam logic [ADDR_W-1:0] OFS_RX_CTL    = 12'h810;
  localparam logic [ADDR_W-1:0] OFS_RX_DAT    = 12'h818;
  localparam logic [ADDR_W-1:0] OFS_IRQ_EN    = 12'h8C0;
  localparam logic [ADDR_W-1:0] OFS_IRQ_CAUSE = 12'h8C4;

  localparam int BIT_OWN = 15;
  localparam int IRQ_TX  = 1;
  localparam int IRQ_RX  = 0;

  typedef struct packed {
    logic             own;
    logic             err;
    logic [LEN_W-1:0] len;
  } tx_stat_t;

  typedef struct packed {
    logic             own;
    logic             err;
    logic             crc;
    logic [LEN_W-1:0] len;
  } rx_stat_t;

  typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_DROP} rx_state_e;

  function automatic logic [31:0] pack_tx(tx_stat_t s);
    return {16'b0, s.own, s.err, 3'b0, s.len};
  endfunction

  function automatic logic [31:0] pack_rx(rx_stat_t s);
    return {16'b0, s.own, s.err, s.crc, 2'b0, s.len};
  endfunction
endpackage

// File: rtl/fm_tx_buf.sv
module fm_tx_buf
  import frame_mailbox_pkg::*;
#(
  parameter int BUF_WORDS = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic             go_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dat_we_i,
  input  logic [31:0]      wdata_i,
  output tx_stat_t         stat_o,
  output logic             done_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  output logic             tx_last_o,
  input  logic             tx_ready_i,
  input  logic             tx_fail_i
);
  localparam int IDX_W = $clog2(BUF_WORDS);
  localparam int PTR_W = $clog2(BUF_WORDS + 1);

  logic [31:0]      mem_q [BUF_WORDS];
  logic [PTR_W-1:0] wptr_q;
  logic             go_q, err_q, done_q;
  logic [LEN_W-1:0] len_q, bidx_q;
  logic [LEN_W-3:0] widx;
  logic [31:0]      word;
  logic             launch, fire, wr_ok;

  assign launch = ctl_we_i && go_i && !go_q;
  assign wr_ok  = dat_we_i && !go_q && (int'(wptr_q) < BUF_WORDS);
  assign widx   = bidx_q[LEN_W-1:2];
  assign word   = (int'(widx) < BUF_WORDS) ? mem_q[widx[IDX_W-1:0]] : '0;

  always_comb begin
    case (bidx_q[1:0])
      2'd0:    tx_data_o = word[31:24];
      2'd1:    tx_data_o = word[23:16];
      2'd2:    tx_data_o = word[15:8];
      default: tx_data_o = word[7:0];
    endcase
  end

  assign tx_valid_o = go_q && (len_q != '0);
  assign tx_last_o  = tx_valid_o && (bidx_q == len_q - LEN_W'(1));
  assign fire       = tx_valid_o && tx_ready_i;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wptr_q[IDX_W-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      len_q  <= '0;
      bidx_q <= '0;
      wptr_q <= '0;
    end else begin
      if (launch) begin
        go_q   <= 1'b1;
        err_q  <= 1'b0;
        done_q <= 1'b0;
        len_q  <= len_i;
        bidx_q <= '0;
        wptr_q <= '0;
      end else begin
        if (ctl_we_i && !go_q) len_q <= len_i;
        if (wr_ok) wptr_q <= wptr_q + PTR_W'(1);
      end
      if (go_q) begin
        if (len_q == '0) begin
          go_q   <= 1'b0;
          done_q <= 1'b1;
        end else if (fire) begin
          if (tx_last_o) begin
            go_q   <= 1'b0;
            done_q <= 1'b1;
            err_q  <= tx_fail_i;
          end else begin
            bidx_q <= bidx_q + LEN_W'(1);
          end
        end
      end
    end
  end

  assign stat_o = '{own: go_q, err: err_q, len: len_q};
  assign done_o = done_q;

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)); // R4
  AST_TX_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && tx_last_o |=> !tx_valid_o && done_o && !stat_o.own); // R5
  AST_TX_DAT_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q && dat_we_i |=> $stable(wptr_q)); // R3
  AST_TX_CTL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q && ctl_we_i |=> $stable(len_q)); // R6
endmodule

// File: rtl/fm_rx_buf.sv
module fm_rx_buf
  import frame_mailbox_pkg::*;
#(
  parameter int BUF_WORDS = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rel_i,
  input  logic        rd_i,
  output logic [31:0] rd_data_o,
  output rx_stat_t    stat_o,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  input  logic        rx_last_i,
  input  logic        rx_err_i,
  input  logic        rx_crc_err_i
);
  localparam int IDX_W = $clog2(BUF_WORDS);
  localparam int PTR_W = $clog2(BUF_WORDS + 1);

  logic [31:0]      mem_q [BUF_WORDS];
  logic [PTR_W-1:0] rptr_q;
  rx_state_e        state_q;
  rx_stat_t         stat_q;
  logic [LEN_W-1:0] cnt_q, cnt_nx;
  logic             acc_err_q;
  logic [LEN_W-3:0] widx;
  logic             take, in_cap;

  assign take   = rx_valid_i && ((state_q == RX_IDLE && !stat_q.own) || state_q == RX_FILL);
  assign widx   = cnt_q[LEN_W-1:2];
  assign in_cap = int'(widx) < BUF_WORDS;
  assign cnt_nx = (cnt_q == '1) ? cnt_q : cnt_q + LEN_W'(1);

  always_ff @(posedge clk_i) begin
    if (take && in_cap) begin
      case (cnt_q[1:0])
        2'd0:    mem_q[widx[IDX_W-1:0]]        <= {rx_data_i, 24'b0};
        2'd1:    mem_q[widx[IDX_W-1:0]][23:16] <= rx_data_i;
        2'd2:    mem_q[widx[IDX_W-1:0]][15:8]  <= rx_data_i;
        default: mem_q[widx[IDX_W-1:0]][7:0]   <= rx_data_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      stat_q    <= '0;
      cnt_q     <= '0;
      acc_err_q <= 1'b0;
      rptr_q    <= '0;
    end else begin
      if (rd_i && int'(rptr_q) < BUF_WORDS) rptr_q <= rptr_q + PTR_W'(1);
      if (rel_i) begin
        stat_q <= '0;
        rptr_q <= '0;
      end
      if (take) begin
        if (rx_last_i) begin
          stat_q    <= '{own: 1'b1, err: acc_err_q | rx_err_i, crc: rx_crc_err_i, len: cnt_nx};
          state_q   <= RX_IDLE;
          cnt_q     <= '0;
          acc_err_q <= 1'b0;
        end else begin
          state_q   <= RX_FILL;
          cnt_q     <= cnt_nx;
          acc_err_q <= acc_err_q | rx_err_i;
        end
      end else if (rx_valid_i) begin
        // held buffer: discard through the end of this frame
        state_q <= rx_last_i ? RX_IDLE : RX_DROP;
      end
    end
  end

  assign rd_data_o = (int'(rptr_q) < BUF_WORDS) ? mem_q[rptr_q[IDX_W-1:0]] : '0;
  assign stat_o    = stat_q;

  AST_RX_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o.own && !rel_i |=> stat_o.own && $stable(stat_o.len) && $stable(stat_o.err)); // R10
  AST_RX_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i && !take |=> !stat_o.own); // R9
endmodule

// File: rtl/fm_irq.sv
module fm_irq
  import frame_mailbox_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_we_i,
  input  logic [1:0] en_wdata_i,
  input  logic       tx_done_i,
  input  logic       rx_rdy_i,
  output logic [1:0] en_o,
  output logic [1:0] cause_o,
  output logic       irq_o
);
  logic [1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  always_comb begin
    cause_o         = '0;
    cause_o[IRQ_TX] = tx_done_i;
    cause_o[IRQ_RX] = rx_rdy_i;
  end

  assign en_o  = en_q;
  assign irq_o = |(cause_o & en_q);
endmodule

// File: rtl/frame_mailbox.sv
module frame_mailbox
  import frame_mailbox_pkg::*;
#(
  parameter int BUF_WORDS = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i,
  input  logic              tx_fail_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_last_i,
  input  logic              rx_err_i,
  input  logic              rx_crc_err_i
);
  tx_stat_t    tx_stat;
  rx_stat_t    rx_stat;
  logic        tx_done;
  logic [31:0] rx_word;
  logic [1:0]  irq_en, irq_cause;

  logic tx_ctl_we, tx_dat_we, rx_rel, rx_rd, en_we;
  assign tx_ctl_we = reg_we_i && (reg_addr_i == OFS_TX_CTL);
  assign tx_dat_we = reg_we_i && (reg_addr_i == OFS_TX_DAT);
  assign rx_rel    = reg_we_i && (reg_addr_i == OFS_RX_CTL) && !reg_wdata_i[BIT_OWN];
  assign rx_rd     = reg_re_i && (reg_addr_i == OFS_RX_DAT);
  assign en_we     = reg_we_i && (reg_addr_i == OFS_IRQ_EN);

  fm_tx_buf #(.BUF_WORDS(BUF_WORDS)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_we_i   (tx_ctl_we),
    .go_i       (reg_wdata_i[BIT_OWN]),
    .len_i      (reg_wdata_i[LEN_W-1:0]),
    .dat_we_i   (tx_dat_we),
    .wdata_i    (reg_wdata_i),
    .stat_o     (tx_stat),
    .done_o     (tx_done),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_last_o  (tx_last_o),
    .tx_ready_i (tx_ready_i),
    .tx_fail_i  (tx_fail_i)
  );

  fm_rx_buf #(.BUF_WORDS(BUF_WORDS)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rel_i        (rx_rel),
    .rd_i         (rx_rd),
    .rd_data_o    (rx_word),
    .stat_o       (rx_stat),
    .rx_data_i    (rx_data_i),
    .rx_valid_i   (rx_valid_i),
    .rx_last_i    (rx_last_i),
    .rx_err_i     (rx_err_i),
    .rx_crc_err_i (rx_crc_err_i)
  );

  fm_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_we_i    (en_we),
    .en_wdata_i (reg_wdata_i[1:0]),
    .tx_done_i  (tx_done),
    .rx_rdy_i   (rx_stat.own),
    .en_o       (irq_en),
    .cause_o    (irq_cause),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_TX_CTL:    reg_rdata_o = pack_tx(tx_stat);
      OFS_RX_CTL:    reg_rdata_o = pack_rx(rx_stat);
      OFS_RX_DAT:    reg_rdata_o = rx_word;
      OFS_IRQ_EN:    reg_rdata_o = {30'b0, irq_en};
      OFS_IRQ_CAUSE: reg_rdata_o = {30'b0, irq_cause};
      default:       reg_rdata_o = '0;
    endcase
  end

  AST_IRQ_RX_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en[IRQ_RX] && rx_stat.own |-> irq_o); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en == 2'b00 |-> !irq_o); // R11
endmodule

// File: tb/frame_mailbox_tb_top.sv
module frame_mailbox_tb_top;
  timeunit 1ns; timeprecision 1ps;
  localparam int BUFW = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, reg_re = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, tx_valid, tx_last, tx_ready = 0, tx_fail = 0;
  logic [7:0] tx_data, rx_data = '0;
  logic rx_valid = 0, rx_last = 0, rx_err = 0, rx_crc = 0;

  int compared = 0, mismatched = 0, cyc = 0, rdy_mode = 0;
  logic [7:0] cap_q[$];

  always #2 clk = ~clk;

  frame_mailbox #(.BUF_WORDS(BUFW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready), .tx_fail_i(tx_fail), .rx_data_i(rx_data),
    .rx_valid_i(rx_valid), .rx_last_i(rx_last), .rx_err_i(rx_err), .rx_crc_err_i(rx_crc));

  // ---------------- reference model ----------------
  bit m_go, m_err, m_done, m_pres, m_rerr, m_rcrc, m_racc;
  int m_len, m_bidx, m_wptr, m_rlen, m_rptr, m_rstate;
  bit [1:0] m_en;
  logic [31:0] m_txm [BUFW];
  logic [31:0] m_rxm [BUFW];
  logic [7:0] m_rxq[$];

  initial for (int i = 0; i < BUFW; i++) begin m_txm[i] = '0; m_rxm[i] = '0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_go = 0; m_err = 0; m_done = 0; m_len = 0; m_bidx = 0; m_wptr = 0;
      m_pres = 0; m_rerr = 0; m_rcrc = 0; m_rlen = 0; m_rptr = 0; m_rstate = 0;
      m_racc = 0; m_en = 0; m_rxq.delete();
    end else begin
      bit old_go, old_pres;
      old_go = m_go; old_pres = m_pres;
      if (m_go) begin
        if (m_len == 0) begin m_go = 0; m_done = 1; end
        else if (tx_ready) begin
          if (m_bidx == m_len - 1) begin m_go = 0; m_done = 1; m_err = tx_fail; end
          else m_bidx++;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          12'h800: if (!old_go) begin
            m_len = int'(reg_wdata[10:0]);
            if (reg_wdata[15]) begin m_go = 1; m_err = 0; m_done = 0; m_bidx = 0; m_wptr = 0; end
          end
          12'h808: if (!old_go && m_wptr < BUFW) begin m_txm[m_wptr] = reg_wdata; m_wptr++; end
          12'h810: if (!reg_wdata[15]) begin
            m_pres = 0; m_rerr = 0; m_rcrc = 0; m_rlen = 0; m_rptr = 0;
          end
          12'h8C0: m_en = reg_wdata[1:0];
          default: ;
        endcase
      end
      if (reg_re && reg_addr == 12'h818 && m_rptr < BUFW) m_rptr++;
      if (rx_valid) begin
        bit acc;
        acc = 0;
        if (m_rstate == 0) begin
          if (old_pres) m_rstate = rx_last ? 0 : 2; else acc = 1;
        end else if (m_rstate == 1) acc = 1;
        else if (rx_last) m_rstate = 0;
        if (acc) begin
          m_rxq.push_back(rx_data);
          m_racc = m_racc | rx_err;
          if (rx_last) begin
            for (int i = 0; i < m_rxq.size(); i++) begin
              if (i % 4 == 0) m_rxm[i/4] = '0;
              m_rxm[i/4][31 - 8*(i%4) -: 8] = m_rxq[i];
            end
            m_pres = 1; m_rlen = m_rxq.size(); m_rerr = m_racc; m_rcrc = rx_crc;
            m_racc = 0; m_rxq.delete(); m_rstate = 0;
          end else m_rstate = 1;
        end
      end
    end
  end

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h800: return {16'b0, m_go, m_err, 3'b0, 11'(m_len)};
      12'h810: return {16'b0, m_pres, m_rerr, m_rcrc, 2'b0, 11'(m_rlen)};
      12'h818: return (m_rptr < BUFW) ? m_rxm[m_rptr] : '0;
      12'h8C0: return {30'b0, m_en};
      12'h8C4: return {30'b0, m_done, m_pres};
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 irq in reset", 32'(irq), 0);
      chk("R1 tx_valid in reset", 32'(tx_valid), 0);
    end else begin
      logic [31:0] w;
      bit ev;
      ev = m_go && m_len != 0;
      chk("R11 irq", 32'(irq), 32'((m_done & m_en[1]) | (m_pres & m_en[0])));
      chk("R4 tx_valid", 32'(tx_valid), 32'(ev));
      if (ev) begin
        w = m_txm[m_bidx/4];
        chk("R4 tx_data", 32'(tx_data), 32'(w[31 - 8*(m_bidx%4) -: 8]));
        chk("R4 tx_last", 32'(tx_last), 32'(m_bidx == m_len - 1));
      end
      if (tx_valid && tx_ready) cap_q.push_back(tx_data);
    end
  end

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    tx_ready = (rdy_mode == 0) ? 1'b0 : (rdy_mode == 1) ? 1'b1 : (cyc % 3 != 0);
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; tick(); reg_we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    reg_re = 1; reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
    chk("model read", v, model_read(a));
    tick(); reg_re = 0;
  endtask

  task automatic rdchk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wait_tx();
    logic [31:0] v;
    for (int i = 0; i < 8000; i++) begin
      rd(12'h800, v);
      if (!v[15]) return;
    end
    chk("R5 transmit never completed", 1, 0);
  endtask

  task automatic send_rx(logic [7:0] b[$], int err_at, bit crc);
    for (int i = 0; i < b.size(); i++) begin
      rx_valid = 1; rx_data = b[i]; rx_last = (i == b.size() - 1);
      rx_err = (i == err_at); rx_crc = crc && (i == b.size() - 1);
      tick();
    end
    rx_valid = 0; rx_last = 0; rx_err = 0; rx_crc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rst_n = 1;
    tick(); tick();
    // R1: every register zero after reset
    rdchk("R1 tx ctl", 12'h800, 0);
    rdchk("R1 rx ctl", 12'h810, 0);
    rdchk("R1 irq en", 12'h8C0, 0);
    rdchk("R1 irq cause", 12'h8C4, 0);
    wr(12'h8C0, 32'h3);
    rdchk("R11 enable readback", 12'h8C0, 32'h3);

    // basic transmit, 7 bytes, stalling ready
    rdy_mode = 2; cap_q.delete();
    wr(12'h808, 32'h11223344);
    wr(12'h808, 32'h55667788);
    wr(12'h800, 32'h8007);
    rdchk("R2 launch sets ready", 12'h800, 32'h8007);
    wait_tx();
    chk("R4 byte count", cap_q.size(), 7);
    for (int i = 0; i < 7 && i < cap_q.size(); i++) chk("R4 byte order", 32'(cap_q[i]), 32'(8'h11 * (i + 1)));
    rdchk("R5 ready cleared", 12'h800, 32'h0007);
    rdchk("R11 tx_done cause", 12'h8C4, 32'h2);
    chk("R11 irq on tx_done", 32'(irq), 1);

    // busy transmitter ignores data and control writes
    rdy_mode = 0; cap_q.delete();
    wr(12'h808, 32'hA0A1A2A3);
    wr(12'h808, 32'hA4A5A6A7);
    wr(12'h808, 32'hA8000000);
    wr(12'h800, 32'h8009);
    rdchk("R2 launch clears tx_done", 12'h8C4, 32'h0);
    wr(12'h808, 32'hDEADBEEF);
    wr(12'h800, 32'h8003);
    rdchk("R6 control write ignored", 12'h800, 32'h8009);
    rdy_mode = 1;
    wait_tx();
    chk("R6 length kept", cap_q.size(), 9);
    if (cap_q.size() == 9) begin
      chk("R3 first byte", 32'(cap_q[0]), 32'hA0);
      chk("R3 busy data write dropped", 32'(cap_q[8]), 32'hA8);
    end

    // transmit failure and error clear on relaunch
    wr(12'h808, 32'h01020304);
    tx_fail = 1;
    wr(12'h800, 32'h8004);
    wait_tx();
    tx_fail = 0;
    rdchk("R5 error bit", 12'h800, 32'h4004);
    wr(12'h800, 32'h8004);
    rdchk("R2 relaunch clears error", 12'h800, 32'h8004);
    wait_tx();

    // zero length
    cap_q.delete();
    wr(12'h800, 32'h8000);
    rdchk("R5 zero length launched", 12'h800, 32'h8000);
    rdchk("R5 zero length done", 12'h800, 32'h0000);
    rdchk("R5 zero length tx_done", 12'h8C4, 32'h2);
    chk("R5 zero length no bytes", cap_q.size(), 0);

    // receive
    send_rx('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06}, -1, 0);
    rdchk("R7 rx posted", 12'h810, 32'h8006);
    rdchk("R11 rx_rdy cause", 12'h8C4, 32'h3);
    rdchk("R8 word 0", 12'h818, 32'h01020304);
    rdchk("R8 word 1 padded", 12'h818, 32'h05060000);
    send_rx('{8'hF1, 8'hF2, 8'hF3}, -1, 1);
    rdchk("R10 held frame kept", 12'h810, 32'h8006);
    wr(12'h810, 32'h0);
    rdchk("R9 released", 12'h810, 32'h0);
    send_rx('{8'h10, 8'h11, 8'h12, 8'h13, 8'h14}, 1, 1);
    rdchk("R7 error and crc flags", 12'h810, 32'hE005);
    rdchk("R9 pointer reset", 12'h818, 32'h10111213);
    rdchk("R8 tail word", 12'h818, 32'h14000000);

    // interrupt masking
    wr(12'h8C0, 32'h0);
    chk("R11 masked", 32'(irq), 0);
    wr(12'h8C0, 32'h1);
    chk("R11 rx enabled", 32'(irq), 1);
    wr(12'h810, 32'h0);
    chk("R11 rx released", 32'(irq), 0);

    // buffer depth cap
    for (int i = 0; i <= BUFW; i++) wr(12'h808, 32'(i));
    rdy_mode = 2; cap_q.delete();
    wr(12'h800, 32'h87FF);
    wait_tx();
    chk("R3 full length", cap_q.size(), 2047);
    if (cap_q.size() == 2047) begin
      chk("R3 word 0 not overwritten", {cap_q[0], cap_q[1], cap_q[2], cap_q[3]}, 32'h0);
      chk("R3 last byte", 32'(cap_q[2046]), 32'h01);
    end

    tick(); tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule